// File: doc/BRIEF.md
# Periodic Tick Timer

A 24-bit down counter for operating-system scheduling. Software loads a reload value and enables the timer. The counter then runs down from that value to zero, reloads and starts again, and it raises a tick interrupt request each time it passes through zero. A sticky count flag records that the counter has passed through zero since the flag was last read, so polling software can see a tick without taking the interrupt.

The counter steps on every second system clock. The step strobe comes from an internal phase toggle, and the timer has no clock input of its own. A tick therefore lasts 2 × (reload + 1) system clocks. A fixed, read-only calibration word gives the reload value that yields a 10 ms tick at the configured system clock frequency. The timer has no external pins. It is reached only through a four-word register port driven by simple read and write strobes.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register reads zero except calibration (enable, interrupt enable, count flag, reload and current value are all 0), and `tickIrq` is low.
- R2: While enabled, the counter steps once every second system clock, and a step from a nonzero value subtracts one.
- R3: A step taken while the current value is zero loads the reload value. The tick period is therefore 2 × (reload + 1) clocks, and after a clear the first step loads the reload value.
- R4: The count flag (control word bit 16) is set by a step from 1 to 0. It is set whether or not the interrupt is enabled. If the set and a clear-on-read fall on the same clock, the set wins.
- R5: Reading the control word (word index 0) returns the flag and clears it on that clock edge.
- R6: When interrupt enable (control bit 1) is set, a step from 1 to 0 makes `tickIrq` high for exactly one clock, starting on the cycle after the step edge. When the bit is clear, `tickIrq` stays low.
- R7: When enable (control bit 0) is clear, the current value holds.
- R8: Any write to the current-value word (index 2) sets the counter to 0 and clears the flag, whatever the data. This write takes priority over a count step on the same edge.
- R9: With a reload value of 0, the counter stays at 0 while enabled, and neither the flag nor `tickIrq` is ever raised.
- R10: The calibration word (index 3) reads SYS_CLK_HZ/(2·TICK_HZ) − 1, which is 499999 (0x7A11F) at the defaults, and writes to it are ignored.
- R11: Unused bits read as zero. Reload and current values occupy bits 23:0. The flag cannot be written, so writing all ones to the control word reads back 0x3 while the flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regSel | input | 2 | Word index: 0 control, 1 reload, 2 current, 3 calibration |
| wr | input | 1 | Write strobe, one word per clock |
| rd | input | 1 | Read strobe; a read of the control word clears the flag |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle that `rd` is high, zero otherwise |
| tickIrq | output | 1 | One-clock tick interrupt request |

## Verification
The hardest thing to pin down from the ports is the exact current value. The step phase is hidden, so one observed edge may or may not carry a step. The stimulus clears the counter and then waits an even number of edges before each read, so that the number of steps taken is fixed whatever the phase. The reads therefore expect exact values such as 999 after four edges and 989 after twenty-four. The irq period is measured edge to edge between pulses, which makes it independent of the phase as well. The flag's clear-on-read and clear-on-write are each checked just after an underflow has been observed, so a stuck flag cannot pass.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // Strobes from control to datapath for one clock
  typedef struct packed {
    logic step;   // perform one count step
    logic clear;  // software write to current value
  } tick_strobe_t;

  typedef enum logic [1:0] {
    REG_CSR    = 2'd0,
    REG_RELOAD = 2'd1,
    REG_CUR    = 2'd2,
    REG_CALIB  = 2'd3
  } tick_reg_e;

  localparam int CSR_EN_BIT   = 0;
  localparam int CSR_IE_BIT   = 1;
  localparam int CSR_FLAG_BIT = 16;
endpackage

// File: rtl/tick_halfrate.sv
module tick_halfrate (
  input  logic clk,
  input  logic rst_n,
  output logic stepEn
);
  logic phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= 1'b0;
    else        phase <= ~phase;
  end

  assign stepEn = phase;
endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         csrWrite,
  input  logic         csrRead,
  input  logic         curWrite,
  input  logic [1:0]   csrData,
  input  logic         stepEn,
  input  logic         atOne,
  output tick_strobe_t strobe,
  output logic         enable,
  output logic         intEn,
  output logic         cntFlag,
  output logic         tickIrq
);
  logic hitZero;

  always_comb begin
    strobe.clear = curWrite;
    strobe.step  = enable && stepEn && !curWrite;
  end

  assign hitZero = strobe.step && atOne;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0;
      intEn  <= 1'b0;
    end else if (csrWrite) begin
      enable <= csrData[CSR_EN_BIT];
      intEn  <= csrData[CSR_IE_BIT];
    end
  end

  // Priority: write-clear, then set on underflow, then clear on read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cntFlag <= 1'b0;
    else if (curWrite) cntFlag <= 1'b0;
    else if (hitZero)  cntFlag <= 1'b1;
    else if (csrRead)  cntFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tickIrq <= 1'b0;
    else        tickIrq <= hitZero && intEn;
  end
endmodule

// File: rtl/tick_datapath.sv
module tick_datapath
  import tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tick_strobe_t     strobe,
  input  logic             reloadWrite,
  input  logic [CNT_W-1:0] reloadData,
  output logic [CNT_W-1:0] curVal,
  output logic [CNT_W-1:0] reloadVal,
  output logic             atOne
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           reloadVal <= '0;
    else if (reloadWrite) reloadVal <= reloadData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            curVal <= '0;
    else if (strobe.clear) curVal <= '0;
    else if (strobe.step) begin
      if (curVal == '0) curVal <= reloadVal;
      else              curVal <= curVal - ONE;
    end
  end

  assign atOne = (curVal == ONE);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int DATA_W     = 32,
  parameter int SYS_CLK_HZ = 100_000_000,
  parameter int TICK_HZ    = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        regSel,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tickIrq
);
  localparam int CALIB_INT = SYS_CLK_HZ / (2 * TICK_HZ) - 1;
  localparam logic [CNT_W-1:0] CALIB_VAL = CNT_W'(CALIB_INT);

  tick_strobe_t strobe;
  logic stepEn, atOne, enable, intEn, cntFlag;
  logic [CNT_W-1:0] curVal, reloadVal;
  logic csrWrite, csrRead, curWrite, reloadWrite;
  logic unusedWdata;

  assign csrWrite    = wr && (regSel == REG_CSR);
  assign csrRead     = rd && (regSel == REG_CSR);
  assign curWrite    = wr && (regSel == REG_CUR);
  assign reloadWrite = wr && (regSel == REG_RELOAD);
  assign unusedWdata = ^{wdata[DATA_W-1:CNT_W], wdata[CNT_W-1:2]};

  tick_halfrate u_half (
    .clk    (clk),
    .rst_n  (rst_n),
    .stepEn (stepEn)
  );

  tick_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .csrWrite (csrWrite),
    .csrRead  (csrRead),
    .curWrite (curWrite),
    .csrData  (wdata[1:0]),
    .stepEn   (stepEn),
    .atOne    (atOne),
    .strobe   (strobe),
    .enable   (enable),
    .intEn    (intEn),
    .cntFlag  (cntFlag),
    .tickIrq  (tickIrq)
  );

  tick_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .reloadWrite (reloadWrite),
    .reloadData  (wdata[CNT_W-1:0]),
    .curVal      (curVal),
    .reloadVal   (reloadVal),
    .atOne       (atOne)
  );

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (regSel)
        REG_CSR: begin
          rdata[CSR_EN_BIT]   = enable;
          rdata[CSR_IE_BIT]   = intEn;
          rdata[CSR_FLAG_BIT] = cntFlag;
        end
        REG_RELOAD: rdata[CNT_W-1:0] = reloadVal;
        REG_CUR:    rdata[CNT_W-1:0] = curVal;
        default:    rdata[CNT_W-1:0] = CALIB_VAL;
      endcase
    end
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W     = 24,
  parameter int DATA_W    = 32,
  parameter int CALIB_VAL = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        regSel,
  input logic              wr,
  input logic              rd,
  input logic [DATA_W-1:0] rdata,
  input logic              tickIrq,
  input logic              stepEn,
  input logic              enable,
  input logic              intEn,
  input logic              cntFlag,
  input logic [CNT_W-1:0]  curVal,
  input logic [CNT_W-1:0]  reloadVal
);
  logic wrCur;
  assign wrCur = wr && (regSel == 2'd2);

  // R2
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stepEn |=> !stepEn);

  // R2
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && stepEn && curVal != '0 && !wrCur) |=> curVal == $past(curVal) - CNT_W'(1));

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && stepEn && curVal == '0 && !wrCur) |=> curVal == $past(reloadVal));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tickIrq |-> ($past(intEn) && cntFlag));

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tickIrq |=> !tickIrq);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !wrCur) |=> $stable(curVal));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrCur |=> (curVal == '0 && !cntFlag));

  // R10
  calib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && regSel == 2'd3) |-> rdata == DATA_W'(CALIB_VAL));
endmodule

bind tick_timer tick_timer_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .CALIB_VAL(CALIB_INT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .regSel(regSel), .wr(wr), .rd(rd),
  .rdata(rdata), .tickIrq(tickIrq), .stepEn(stepEn), .enable(enable),
  .intEn(intEn), .cntFlag(cntFlag), .curVal(curVal), .reloadVal(reloadVal)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam logic [31:0] CALIB = 32'd499999;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tickIrq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  sb_item_t sbQ[$];

  always #5 clk = ~clk;

  tick_timer i_tick_timer (
    .clk(clk), .rst_n(rst_n), .regSel(regSel), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata), .tickIrq(tickIrq)
  );

  task automatic checkEq(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Monitor: samples 1 ns before the next rising edge
  always @(negedge clk) begin
    #4;
    if (rd) begin
      if (sbQ.size() == 0) begin
        compared++;
        mismatched++;
        $display("FAIL scoreboard: actual 0x%08h expected nothing queued", rdata);
      end else begin
        sb_item_t it;
        it = sbQ.pop_front();
        checkEq(it.req, rdata, it.exp);
      end
    end
  end

  // All driver tasks start and end at a falling edge
  task automatic writeReg(logic [1:0] sel, logic [31:0] data);
    regSel = sel; wdata = data; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic readReg(logic [1:0] sel, logic [31:0] exp, string req);
    sb_item_t it;
    it.exp = exp; it.req = req;
    sbQ.push_back(it);
    regSel = sel; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countIrq(int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tickIrq) hits++;
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    int hits;
    int gap;
    bit seen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    checkEq("R1 irq", {31'd0, tickIrq}, 32'd0);
    readReg(2'd0, 32'd0, "R1 control");
    readReg(2'd1, 32'd0, "R1 reload");
    readReg(2'd2, 32'd0, "R1 current");
    readReg(2'd3, CALIB, "R10 calibration");

    // R10 calibration is read-only; R11 reload width
    writeReg(2'd3, 32'h0000_0123);
    readReg(2'd3, CALIB, "R10 write ignored");
    writeReg(2'd1, 32'hFFFF_FFFF);
    readReg(2'd1, 32'h00FF_FFFF, "R11 reload width");
    writeReg(2'd1, 32'd0);

    // R9 zero reload: no tick, flag bit not writable (R11)
    writeReg(2'd0, 32'hFFFF_FFFF);
    countIrq(50, hits);
    checkEq("R9 irq count", hits, 32'd0);
    readReg(2'd2, 32'd0, "R9 current stays zero");
    readReg(2'd0, 32'h0000_0003, "R9 R11 control");

    // R3 R6 periodic tick with reload 4
    writeReg(2'd0, 32'd0);
    writeReg(2'd1, 32'd4);
    writeReg(2'd2, 32'h0000_0ABC);
    writeReg(2'd0, 32'd3);
    seen = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (tickIrq) seen = 1'b1;
    end
    checkEq("R6 first irq", {31'd0, seen}, 32'd1);
    for (int k = 0; k < 2; k++) begin
      gap = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        gap++;
        if (gap == 1) checkEq("R6 pulse width", {31'd0, tickIrq}, 32'd0);
        if (tickIrq) break;
      end
      checkEq("R3 period", gap, 32'd10);
    end

    // R4 flag set, R5 cleared on read
    readReg(2'd0, 32'h0001_0003, "R4 flag set");
    readReg(2'd0, 32'h0000_0003, "R5 cleared by read");

    // R6 gating with interrupt disabled
    writeReg(2'd0, 32'd1);
    countIrq(40, hits);
    checkEq("R6 gated irq", hits, 32'd0);
    // R8 current write clears flag and counter
    writeReg(2'd0, 32'd0);
    writeReg(2'd2, 32'h00FF_FFFF);
    readReg(2'd0, 32'd0, "R8 flag cleared");
    readReg(2'd2, 32'd0, "R8 counter cleared");
    idle(10);
    readReg(2'd2, 32'd0, "R7 no count while disabled");
    // R4 flag sets while interrupt gated
    writeReg(2'd0, 32'd1);
    idle(30);
    readReg(2'd0, 32'h0001_0001, "R4 flag without irq");

    // R2 R3 exact half-rate stepping from a clear
    writeReg(2'd0, 32'd0);
    writeReg(2'd1, 32'd1000);
    writeReg(2'd2, 32'd0);
    writeReg(2'd0, 32'd1);
    idle(4);
    readReg(2'd2, 32'd999, "R3 load then step");
    idle(19);
    readReg(2'd2, 32'd989, "R2 half rate");
    writeReg(2'd0, 32'd0);
    idle(6);
    readReg(2'd2, 32'd988, "R7 hold value");

    idle(2);
    checkEq("scoreboard drained", sbQ.size(), 32'd0);
    done = 1'b1;
    finishRun();
  end
endmodule